// File: doc/BRIEF.md
# Oversampled UART Receive Engine with Glitch Rejection

This block turns a synchronised serial receive line into bytes. A tick arrives at sixteen times the baud rate, and the engine samples the line on each tick. A falling edge on the line does not commit the engine to a frame at once. The line must first read low for a programmable number of consecutive ticks. Each bit of the frame is then decided by a 2-of-3 vote over the sub-samples at tick positions 7, 8 and 9 of that bit, which sit around mid-bit and away from the edges.

Each accepted byte is presented with a one-clock valid strobe. Error pulses go out alongside the data for parity mismatch, overrun, framing failure and a line held low for a whole frame. A separate pulse marks each start that was rejected, for an external counter.

After a framing failure the engine drops the frame. It then waits until the line has stayed high for a programmable number of ticks before it watches for a new start. A FIFO, a baud divider and any register access are outside this block.

Top module: `noisy_uart_rx`

## Requirements
- R1: A start is accepted only after `cfg_qual_len` consecutive low ticks while idle (a value of 0 acts as 1; the range is 1 to 7). The first of those low ticks is sub-sample 0 of the start bit.
- R2: While idle, a low run shorter than the qualify length that is followed by a high tick produces one `false_start` pulse and no frame.
- R3: Each bit is the majority of its sub-samples 7, 8 and 9. One sub-sample of opposite level in that cluster does not change the decoded bit.
- R4: The frame carries 8 data bits, least significant first, then an optional parity bit, then one stop bit. `rx_valid` pulses for one clock after the tick that takes sub-sample 9 of the stop bit. Counting the first low tick as tick 0, that is tick 153 without parity and tick 169 with parity.
- R5: `cfg_parity` encodes 0 as none, 1 as even (the parity bit equals the XOR of the data), 2 as odd, 3 as mark (the bit is 1) and 4 as space (the bit is 0); values 5 to 7 act as none. When the received parity bit does not match, `err_parity` is raised in the same clock as `rx_valid`.
- R6: If the stop bit votes low, `err_frame` pulses at the stop-bit decision and `rx_valid` stays low for that frame.
- R7: `err_break` pulses together with `err_frame` when the start bit, all data bits, the parity bit (when used) and the stop bit all voted low.
- R8: `err_overrun` is raised with `rx_valid` when no `rd_ack` has been seen since the previous `rx_valid`. An `rd_ack` in the same clock as the new strobe counts as reading the previous byte.
- R9: After `err_frame`, no start is qualified until `cfg_idle_len` consecutive high ticks have been seen (a value of 0 acts as 1). A low tick restarts that count.
- R10: If the start bit votes high at its centre, the engine returns to idle and pulses `false_start`. No byte and no error is reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | One-clock pulse at 16x the baud rate |
| rx_in | input | 1 | Receive line, already synchronised |
| cfg_parity | input | 3 | Parity mode (see R5) |
| cfg_qual_len | input | 3 | Consecutive low ticks needed to accept a start |
| cfg_idle_len | input | 8 | High ticks needed to re-arm after a framing error |
| rd_ack | input | 1 | Consumer has taken the current byte |
| rx_data | output | 8 | Last accepted byte |
| rx_valid | output | 1 | One-clock strobe for a new byte |
| err_parity | output | 1 | Parity mismatch, valid with `rx_valid` |
| err_overrun | output | 1 | Previous byte unread, valid with `rx_valid` |
| err_frame | output | 1 | Stop bit read low (pulse) |
| err_break | output | 1 | Whole frame read low (pulse with `err_frame`) |
| false_start | output | 1 | Rejected start (pulse) |

## Verification
Every result is a registered pulse that comes one clock after the tick that completes its decision. For a frame, that tick is sub-sample 9 of the stop bit, so the strobe is due 154 or 170 ticks after the first low tick. For a rejected start, it is the first high tick after a short low run, or sub-sample 9 of the start bit. The bench counts ticks from the first low tick of each frame and compares the tick count at the strobe with 16·k+10, where k is the stop-bit index. It drives a tick in every clock and reads the outputs on the falling edge that follows the registering edge, so each pulse is seen exactly once.

// File: rtl/urx_pkg.sv
// Shared types and parity helpers for the oversampled receive engine.
// Assumes parity codes: 0 none, 1 even, 2 odd, 3 mark, 4 space, others none.
package urx_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_FRAME  = 2'd1,
        ST_RESYNC = 2'd2
    } urx_state_t;

    localparam logic [2:0] PAR_NONE  = 3'd0;
    localparam logic [2:0] PAR_EVEN  = 3'd1;
    localparam logic [2:0] PAR_ODD   = 3'd2;
    localparam logic [2:0] PAR_MARK  = 3'd3;
    localparam logic [2:0] PAR_SPACE = 3'd4;

    // True when the mode carries a parity bit in the frame.
    function automatic logic par_used(input logic [2:0] mode);
        return (mode == PAR_EVEN) || (mode == PAR_ODD) ||
               (mode == PAR_MARK) || (mode == PAR_SPACE);
    endfunction

    // Parity bit level the transmitter should have sent for this data.
    function automatic logic par_expect(input logic [2:0] mode, input logic [7:0] d);
        case (mode)
            PAR_EVEN:  return ^d;
            PAR_ODD:   return ~(^d);
            PAR_MARK:  return 1'b1;
            default:   return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/urx_start_qual.sv
// Start qualifier: counts consecutive low ticks while armed and flags a
// confirmed start once the run reaches the programmed length, or a rejected
// start when the line returns high first. Assumes rx is synchronised.
module urx_start_qual #(
    parameter int QUAL_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              arm,
    input  logic              rx,
    input  logic [QUAL_W-1:0] qual_len,
    output logic [QUAL_W-1:0] need,
    output logic              start_hit,
    output logic              glitch_rej
);
    logic [QUAL_W-1:0] run;

    // Effective length: zero is treated as one.
    always_comb need = (qual_len == '0) ? QUAL_W'(1) : qual_len;

    // Decisions are taken on the tick that completes or breaks the run.
    always_comb begin
        start_hit  = tick && arm && !rx && (({1'b0, run} + 1'b1) >= {1'b0, need});
        glitch_rej = tick && arm && rx && (run != '0);
    end

    // Low-run counter, cleared when disarmed, on high, or on acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n)              run <= '0;
        else if (!arm)           run <= '0;
        else if (tick) begin
            if (rx || start_hit) run <= '0;
            else                 run <= run + 1'b1;
        end
    end

    // R2
    reject_after_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        glitch_rej |-> (run != '0) && $past(arm));

endmodule

// File: rtl/urx_vote3.sv
// Three-input majority voter for one bit decision; purely combinational.
module urx_vote3 (
    input  logic a,
    input  logic b,
    input  logic c,
    output logic y
);
    // Two of three agree.
    always_comb y = (a & b) | (a & c) | (b & c);
endmodule

// File: rtl/noisy_uart_rx.sv
// Oversampled UART receive engine. Qualifies starts over consecutive low
// ticks, votes each bit over sub-samples MID-1..MID+1, checks parity and
// stop, reports overrun and break, and resyncs on idle after a framing error.
// Assumes rx_in is synchronised and config is stable during a frame.
module noisy_uart_rx #(
    parameter int DATA_W = 8,
    parameter int OSR    = 16,
    parameter int QUAL_W = 3,
    parameter int IDLE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              rx_in,
    input  logic [2:0]        cfg_parity,
    input  logic [QUAL_W-1:0] cfg_qual_len,
    input  logic [IDLE_W-1:0] cfg_idle_len,
    input  logic              rd_ack,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_valid,
    output logic              err_parity,
    output logic              err_overrun,
    output logic              err_frame,
    output logic              err_break,
    output logic              false_start
);
    import urx_pkg::*;

    localparam int PH_W  = $clog2(OSR);
    localparam int BIT_W = $clog2(DATA_W + 3);
    localparam logic [PH_W-1:0]  PH_A    = PH_W'(OSR / 2 - 1);
    localparam logic [PH_W-1:0]  PH_B    = PH_W'(OSR / 2);
    localparam logic [PH_W-1:0]  PH_C    = PH_W'(OSR / 2 + 1);
    localparam logic [PH_W-1:0]  PH_LAST = PH_W'(OSR - 1);
    localparam logic [BIT_W-1:0] IDX_PAR = BIT_W'(DATA_W + 1);

    urx_state_t        st;
    logic [PH_W-1:0]   phase;
    logic [BIT_W-1:0]  bit_idx;
    logic              sub_a, sub_b, vote;
    logic [DATA_W-1:0] shreg;
    logic              par_bit_r, all_low, unread;
    logic [IDLE_W-1:0] resync_cnt, idle_need;
    logic [QUAL_W-1:0] qual_need;
    logic              start_hit, glitch_rej, par_on, decide;

    urx_start_qual #(.QUAL_W(QUAL_W)) u_qual (
        .clk(clk), .rst_n(rst_n), .tick(tick), .arm(st == ST_IDLE), .rx(rx_in),
        .qual_len(cfg_qual_len), .need(qual_need),
        .start_hit(start_hit), .glitch_rej(glitch_rej)
    );

    urx_vote3 u_vote (.a(sub_a), .b(sub_b), .c(rx_in), .y(vote));

    // Frame shape and decision instant.
    always_comb begin
        par_on    = par_used(cfg_parity);
        decide    = tick && (st == ST_FRAME) && (phase == PH_C);
        idle_need = (cfg_idle_len == '0) ? IDLE_W'(1) : cfg_idle_len;
    end

    // Receive state machine, bit timing, decisions and result strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= ST_IDLE; phase <= '0; bit_idx <= '0;
            sub_a <= 1'b1; sub_b <= 1'b1; shreg <= '0; par_bit_r <= 1'b0;
            all_low <= 1'b0; unread <= 1'b0; resync_cnt <= '0; rx_data <= '0;
            rx_valid <= 1'b0; err_parity <= 1'b0; err_overrun <= 1'b0;
            err_frame <= 1'b0; err_break <= 1'b0; false_start <= 1'b0;
        end else begin
            rx_valid <= 1'b0; err_parity <= 1'b0; err_overrun <= 1'b0;
            err_frame <= 1'b0; err_break <= 1'b0; false_start <= 1'b0;
            if (rd_ack) unread <= 1'b0;
            case (st)
                ST_IDLE: begin
                    if (start_hit) begin
                        st <= ST_FRAME; phase <= PH_W'(qual_need);
                        bit_idx <= '0; all_low <= 1'b1;
                    end else if (glitch_rej) begin
                        false_start <= 1'b1;
                    end
                end
                ST_FRAME: if (tick) begin
                    phase <= (phase == PH_LAST) ? '0 : phase + 1'b1;
                    if (phase == PH_LAST) bit_idx <= bit_idx + 1'b1;
                    if (phase == PH_A) sub_a <= rx_in;
                    if (phase == PH_B) sub_b <= rx_in;
                    if (decide) begin
                        if (vote) all_low <= 1'b0;
                        if (bit_idx == '0) begin
                            if (vote) begin false_start <= 1'b1; st <= ST_IDLE; end
                        end else if (bit_idx <= BIT_W'(DATA_W)) begin
                            shreg <= {vote, shreg[DATA_W-1:1]};
                        end else if (par_on && bit_idx == IDX_PAR) begin
                            par_bit_r <= vote;
                        end else if (vote) begin
                            rx_valid    <= 1'b1;
                            rx_data     <= shreg;
                            err_parity  <= par_on && (par_bit_r != par_expect(cfg_parity, shreg));
                            err_overrun <= unread && !rd_ack;
                            unread      <= 1'b1;
                            st          <= ST_IDLE;
                        end else begin
                            err_frame  <= 1'b1;
                            err_break  <= all_low;
                            resync_cnt <= '0;
                            st         <= ST_RESYNC;
                        end
                    end
                end
                ST_RESYNC: if (tick) begin
                    if (!rx_in) resync_cnt <= '0;
                    else if (({1'b0, resync_cnt} + 1'b1) >= {1'b0, idle_need}) st <= ST_IDLE;
                    else resync_cnt <= resync_cnt + 1'b1;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    // R6
    valid_frame_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rx_valid && err_frame));
    // R7
    break_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_break |-> err_frame);
    // R8
    overrun_with_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_overrun |-> rx_valid);
    // R4
    strobe_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid || err_frame) |-> $past(tick));
    // R9
    rearm_needs_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE && $past(st) == ST_RESYNC) |-> ($past(rx_in) && $past(tick)));
    // R1
    frame_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_FRAME && $past(st) == ST_IDLE) |-> !$past(rx_in));

endmodule

// File: tb/sim_noisy_uart_rx.sv
// Bench: random frames with single sub-sample glitches plus directed corners.
module sim_noisy_uart_rx;
    logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, rx_in = 1'b1, rd_ack = 1'b0;
    logic [2:0] cfg_parity = 3'd0, cfg_qual_len = 3'd3;
    logic [7:0] cfg_idle_len = 8'd20;
    logic [7:0] rx_data;
    logic rx_valid, err_parity, err_overrun, err_frame, err_break, false_start;

    int nchk = 0, nerr = 0, tcount = 0, t0 = 0;
    int got_valid, got_fe, got_fs, got_at;
    logic [7:0] got_data;
    logic got_pe, got_oe, got_br;
    bit auto_ack = 1'b1, done = 1'b0;

    always #5 clk = ~clk;

    noisy_uart_rx u0 (
        .clk(clk), .rst_n(rst_n), .tick(tick), .rx_in(rx_in),
        .cfg_parity(cfg_parity), .cfg_qual_len(cfg_qual_len),
        .cfg_idle_len(cfg_idle_len), .rd_ack(rd_ack), .rx_data(rx_data),
        .rx_valid(rx_valid), .err_parity(err_parity), .err_overrun(err_overrun),
        .err_frame(err_frame), .err_break(err_break), .false_start(false_start)
    );

    // Output monitor, sampled on the falling edge after each registering edge.
    always @(negedge clk) begin
        rd_ack = auto_ack && rx_valid;
        if (rx_valid) begin
            got_valid++; got_data = rx_data; got_pe = err_parity;
            got_oe = err_overrun; got_at = tcount - t0;
        end
        if (err_frame) begin got_fe++; got_br = err_break; got_at = tcount - t0; end
        if (false_start) got_fs++;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic clr_mon();
        got_valid = 0; got_fe = 0; got_fs = 0; got_at = -1;
        got_data = 8'h00; got_pe = 1'b0; got_oe = 1'b0; got_br = 1'b0;
    endtask

    task automatic tick_once(input logic v);
        @(negedge clk);
        rx_in = v; tick = 1'b1;
        @(posedge clk);
        #1 tick = 1'b0; tcount++;
    endtask

    task automatic run_level(input logic v, input int n);
        for (int i = 0; i < n; i++) tick_once(v);
    endtask

    function automatic logic exp_par(input logic [2:0] m, input logic [7:0] d);
        case (m)
            3'd1: return ^d;
            3'd2: return ~(^d);
            3'd3: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    function automatic bit par_on(input logic [2:0] m);
        return (m >= 3'd1) && (m <= 3'd4);
    endfunction

    // One frame; gbit/gsub place a single inverted sub-sample (gbit<0: none).
    task automatic send_frame(input logic [7:0] d, input logic stop_lvl, input bit flip_par,
                              input int gbit, input int gsub, input int idle_after);
        int nb;
        logic lvl;
        nb = par_on(cfg_parity) ? 11 : 10;
        t0 = tcount;
        for (int b = 0; b < nb; b++) begin
            if (b == 0) lvl = 1'b0;
            else if (b <= 8) lvl = d[b-1];
            else if (b == nb - 1) lvl = stop_lvl;
            else lvl = exp_par(cfg_parity, d) ^ flip_par;
            for (int s = 0; s < 16; s++)
                tick_once((b == gbit && s == gsub) ? ~lvl : lvl);
        end
        run_level(1'b1, idle_after);
    endtask

    initial begin
        void'($urandom(32'h5eed_0427));
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        @(negedge clk);
        // R4 reset state
        check(rx_valid == 0 && err_frame == 0 && false_start == 0 && rx_data == 8'h00,
              "R4 reset outputs", int'(rx_valid), 0);
        run_level(1'b1, 5);

        // R3 R4 R5 random frames with one glitched sub-sample inside a vote cluster
        for (int f = 0; f < 40; f++) begin
            logic [7:0] d;
            int nb, gb;
            d = 8'($urandom);
            cfg_parity   = 3'($urandom % 5);
            cfg_qual_len = 3'(1 + $urandom % 7);
            nb = par_on(cfg_parity) ? 11 : 10;
            gb = ($urandom % 2 == 0) ? -1 : int'($urandom % nb);
            clr_mon();
            send_frame(d, 1'b1, 1'b0, gb, 7 + int'($urandom % 3), 20);
            check(got_valid == 1, "R3 one byte per frame", got_valid, 1);
            check(got_data == d, "R3 data after vote", int'(got_data), int'(d));
            check(got_at == 16 * (nb - 1) + 10, "R4 strobe tick", got_at, 16 * (nb - 1) + 10);
            check(got_pe == 1'b0, "R5 no parity error", int'(got_pe), 0);
            check(got_fe == 0 && got_oe == 1'b0, "R6 no frame or overrun error", got_fe, 0);
        end

        // R5 wrong parity bit in even and odd modes
        cfg_qual_len = 3'd3;
        for (int m = 1; m <= 2; m++) begin
            cfg_parity = 3'(m);
            clr_mon();
            send_frame(8'hB6, 1'b1, 1'b1, -1, 0, 20);
            check(got_valid == 1 && got_pe == 1'b1, "R5 parity mismatch flagged", int'(got_pe), 1);
        end

        // R2 short low run rejected
        cfg_parity = 3'd0; cfg_qual_len = 3'd4;
        clr_mon();
        run_level(1'b0, 3); run_level(1'b1, 30);
        check(got_fs == 1, "R2 false start pulse", got_fs, 1);
        check(got_valid == 0 && got_fe == 0, "R2 no frame from glitch", got_valid, 0);

        // R1 long qualify length still decodes
        cfg_qual_len = 3'd7;
        clr_mon();
        send_frame(8'h3C, 1'b1, 1'b0, -1, 0, 20);
        check(got_valid == 1 && got_data == 8'h3C, "R1 start with N=7", int'(got_data), 8'h3C);
        check(got_fs == 0, "R1 no rejection on valid start", got_fs, 0);

        // R10 qualified low that is high at the start-bit centre
        cfg_qual_len = 3'd3;
        clr_mon();
        run_level(1'b0, 5); run_level(1'b1, 40);
        check(got_fs == 1 && got_valid == 0, "R10 start vote high rejected", got_fs, 1);

        // R6 stop low, then R9 resync swallows a frame seen before idle
        cfg_idle_len = 8'd20;
        clr_mon();
        send_frame(8'h5A, 1'b0, 1'b0, -1, 0, 3);
        check(got_fe == 1 && got_valid == 0, "R6 framing error, no byte", got_fe, 1);
        check(got_br == 1'b0, "R7 no break on nonzero data", int'(got_br), 0);
        clr_mon();
        send_frame(8'h00, 1'b1, 1'b0, -1, 0, 20);
        check(got_valid == 0 && got_fe == 0, "R9 frame ignored during resync", got_valid, 0);
        clr_mon();
        send_frame(8'hC3, 1'b1, 1'b0, -1, 0, 20);
        check(got_valid == 1 && got_data == 8'hC3, "R9 rearmed after idle", int'(got_data), 8'hC3);

        // R7 break: whole frame low
        clr_mon();
        send_frame(8'h00, 1'b0, 1'b0, -1, 0, 25);
        check(got_fe == 1 && got_br == 1'b1, "R7 break flagged", int'(got_br), 1);

        // R8 overrun sequence
        auto_ack = 1'b0;
        clr_mon(); send_frame(8'h11, 1'b1, 1'b0, -1, 0, 20);
        check(got_oe == 1'b0, "R8 first unread byte no overrun", int'(got_oe), 0);
        clr_mon(); send_frame(8'h22, 1'b1, 1'b0, -1, 0, 20);
        check(got_oe == 1'b1, "R8 overrun on second byte", int'(got_oe), 1);
        auto_ack = 1'b1;
        clr_mon(); send_frame(8'h33, 1'b1, 1'b0, -1, 0, 20);
        check(got_oe == 1'b1, "R8 still unread before this strobe", int'(got_oe), 1);
        clr_mon(); send_frame(8'h44, 1'b1, 1'b0, -1, 0, 20);
        check(got_oe == 1'b0, "R8 no overrun after ack", int'(got_oe), 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nchk++; nerr++;
            $display("FAIL R4 watchdog actual=%0d expected=%0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end
endmodule